// File: doc/BRIEF.md
# Reset Cause Recorder with Watchdog Timer

This block records why the chip was last reset and also runs a watchdog timer. Four request pins feed it: a power-on request, a low-voltage request, an oscillator-monitor failure and a PLL-monitor failure. The watchdog adds two more causes of its own: a timeout, and a wrong byte written to its service register. Any of these causes drives `sys_rst` high for a fixed number of cycles. During that window the watchdog state is set up again. Its rate is reloaded from a nonvolatile option value that is sampled on every reset.

A set of five sticky cause flags survives every reset except power-on. Each flag has its own rule for what power-on does to it. Software reads the flags over a small register port and clears them by writing ones. Software also sets the watchdog rate and services the timer by writing 0x55 and then 0xAA.

Register map, by `bus_addr` / `bus_raddr`:
- 0 holds the control register, with the rate in bits [2:0].
- 1 is the service register, which always reads 0.
- 2 holds the flags.
- 3 is unused and reads 0.

Top module: `reset_cause_wdog`

## Requirements
- R1: While `por_req` is high, the power-on flag (bit 0) and the low-voltage flag (bit 1) are set, and the watchdog flag (bit 2), oscillator flag (bit 3) and PLL flag (bit 4) are cleared.
- R2: A low-voltage, oscillator-fail, PLL-fail or watchdog request sets only its own flag, and leaves every other flag unchanged.
- R3: When several non-power-on sources request a reset in the same cycle, all of their flags are set together.
- R4: Writing to address 2 clears each flag whose data bit is 1, and a 0 bit has no effect. The write is ignored while `sys_rst` is high. A source that sets a flag in the same cycle wins over the clear.
- R5: A request sampled on a clock edge raises `sys_rst` after that edge, and `sys_rst` stays high for HOLD_CYCLES (16) cycles. A new request restarts the window. `sys_rst` never rises without a request.
- R6: While a reset is active, the watchdog rate is loaded from `opt_rate`, the count is cleared and the service sequence is disarmed.
- R7: A rate of 0 disables the watchdog: there is no timeout, and service writes have no effect.
- R8: With rate r in 1..7 and no valid service, a watchdog reset is requested on the 2^(RATE_BASE+RATE_STEP·r)-th cycle after the count was cleared.
- R9: With the watchdog enabled, 0x55 arms the service sequence and 0xAA after an arm restarts the count. Any other byte, or 0xAA with no arm before it, requests a watchdog reset in the cycle of the write.
- R10: Writing address 0 sets the rate from data bits [2:0] and clears the count. Reads return the rate at address 0, the flags at address 2, and 0 at addresses 1 and 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_req | input | 1 | Power-on reset request; also initialises the block |
| lvd_req | input | 1 | Low-voltage reset request |
| osc_fail | input | 1 | Oscillator monitor failure |
| pll_fail | input | 1 | PLL monitor failure |
| opt_rate | input | 3 | Nonvolatile watchdog rate, sampled during reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Write address |
| bus_wdata | input | 8 | Write data |
| bus_raddr | input | 2 | Read address |
| bus_rdata | output | 8 | Read data (combinational) |
| sys_rst | output | 1 | System reset output |
| cause_flags | output | 5 | Sticky reset-cause flags |

## Verification
The bench builds the block with RATE_BASE=3 and RATE_STEP=1. With these values the timeouts run from 16 cycles at rate 1 to 1024 cycles at rate 7. Every rate, a complete timeout and a long sequence of service cycles therefore fit into a short run. HOLD_CYCLES keeps its default of 16, so the duration of the reset window is checked at its real value.

// File: rtl/rcw_pkg.sv
package rcw_pkg;
    localparam int unsigned FLAG_W = 5;
    localparam int unsigned FLG_POR = 0;
    localparam int unsigned FLG_LVD = 1;
    localparam int unsigned FLG_COP = 2;
    localparam int unsigned FLG_OSC = 3;
    localparam int unsigned FLG_PLL = 4;

    typedef enum logic [1:0] {
        REG_CTRL  = 2'd0,
        REG_SVC   = 2'd1,
        REG_FLAGS = 2'd2,
        REG_SPARE = 2'd3
    } reg_sel_e;

    localparam logic [7:0] SVC_ARM  = 8'h55;
    localparam logic [7:0] SVC_KICK = 8'hAA;
endpackage

// File: rtl/rcw_rst_seq.sv
module rcw_rst_seq #(
    parameter int unsigned HOLD_CYCLES = 16
) (
    input  logic clk,
    input  logic por_req,
    input  logic req_any,
    output logic rst_active
);
    localparam int unsigned CW = $clog2(HOLD_CYCLES + 1);
    localparam logic [CW-1:0] LOAD = CW'(HOLD_CYCLES);

    typedef struct packed {
        logic [CW-1:0] left;
        logic          active;
    } seq_t;

    seq_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (req_any) begin
            st_d.left   = LOAD;
            st_d.active = 1'b1;
        end else if (st_q.left != '0) begin
            st_d.left   = st_q.left - 1'b1;
            st_d.active = (st_q.left > 1);
        end else begin
            st_d.active = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign rst_active = st_q.active;

    // R5: a request raises the reset output on the next cycle
    assert_req_asserts_R5: assert property (@(posedge clk) disable iff (por_req)
        req_any |=> rst_active);
    // R5: the output only rises in response to a request
    assert_no_spurious_R5: assert property (@(posedge clk) disable iff (por_req)
        (!req_any && !rst_active) |=> !rst_active);
endmodule

// File: rtl/rcw_cop_timer.sv
module rcw_cop_timer
    import rcw_pkg::*;
#(
    parameter int unsigned RATE_BASE = 8,
    parameter int unsigned RATE_STEP = 2
) (
    input  logic       clk,
    input  logic       por_req,
    input  logic       hold,
    input  logic       rst_active,
    input  logic [2:0] opt_rate,
    input  logic       ctrl_we,
    input  logic       svc_we,
    input  logic [7:0] wdata,
    output logic [2:0] rate_o,
    output logic       cop_req
);
    localparam int unsigned CW = RATE_BASE + RATE_STEP * 7;

    typedef struct packed {
        logic [2:0]    rate;
        logic [CW-1:0] cnt;
        logic          armed;
    } cop_t;

    cop_t st_d, st_q;

    logic          enabled;
    logic          svc_live;
    logic          kick_ok;
    logic          bad_svc;
    logic          expire;
    logic [CW:0]   span_ext;
    logic [CW-1:0] terminal;

    always_comb begin
        span_ext = (CW + 1)'(1) << (RATE_BASE + RATE_STEP * 32'(st_q.rate));
        terminal = CW'(span_ext - 1'b1);
    end

    always_comb begin
        enabled  = (st_q.rate != 3'd0);
        svc_live = svc_we && enabled;
        kick_ok  = svc_live && (wdata == SVC_KICK) && st_q.armed;
        bad_svc  = svc_live && !kick_ok && (wdata != SVC_ARM);
        expire   = enabled && !rst_active && (st_q.cnt == terminal) && !kick_ok;
        cop_req  = bad_svc || expire;
    end

    always_comb begin
        st_d = st_q;
        if (hold) begin
            st_d.rate  = opt_rate;
            st_d.cnt   = '0;
            st_d.armed = 1'b0;
        end else if (ctrl_we) begin
            st_d.rate  = wdata[2:0];
            st_d.cnt   = '0;
            st_d.armed = 1'b0;
        end else if (enabled) begin
            if (kick_ok) begin
                st_d.cnt   = '0;
                st_d.armed = 1'b0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
                if (svc_live && wdata == SVC_ARM) begin
                    st_d.armed = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign rate_o = st_q.rate;

    // R7: a disabled watchdog never requests a reset
    assert_disabled_quiet_R7: assert property (@(posedge clk) disable iff (por_req)
        (rate_o == 3'd0) |-> !cop_req);
    // R6: the rate is taken from the option input during reset
    assert_opt_load_R6: assert property (@(posedge clk) disable iff (por_req)
        hold |=> (rate_o == $past(opt_rate)));
endmodule

// File: rtl/rcw_flags.sv
module rcw_flags
    import rcw_pkg::*;
(
    input  logic              clk,
    input  logic              por_req,
    input  logic              lvd_req,
    input  logic              osc_fail,
    input  logic              pll_fail,
    input  logic              cop_req,
    input  logic              clr_we,
    input  logic [FLAG_W-1:0] clr_mask,
    output logic [FLAG_W-1:0] flags_o
);
    typedef struct packed {
        logic [FLAG_W-1:0] bits;
    } flg_t;

    flg_t st_d, st_q;
    logic [FLAG_W-1:0] set_vec;

    always_comb begin
        set_vec          = '0;
        set_vec[FLG_LVD] = lvd_req;
        set_vec[FLG_COP] = cop_req;
        set_vec[FLG_OSC] = osc_fail;
        set_vec[FLG_PLL] = pll_fail;
    end

    always_comb begin
        st_d = st_q;
        if (por_req) begin
            st_d.bits          = '0;
            st_d.bits[FLG_POR] = 1'b1;
            st_d.bits[FLG_LVD] = 1'b1;
        end else begin
            if (clr_we) begin
                st_d.bits = st_d.bits & ~clr_mask;
            end
            st_d.bits = st_d.bits | set_vec;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign flags_o = st_q.bits;

    // R1: power-on leaves exactly the power-on and low-voltage flags set
    assert_por_pattern_R1: assert property (@(posedge clk) disable iff (por_req)
        $fell(por_req) |-> (flags_o == 5'b00011));
    // R2: without a clearing write no flag drops
    assert_sticky_R2: assert property (@(posedge clk) disable iff (por_req)
        !clr_we |=> ((~flags_o & $past(flags_o)) == '0));
endmodule

// File: rtl/reset_cause_wdog.sv
module reset_cause_wdog
    import rcw_pkg::*;
#(
    parameter int unsigned HOLD_CYCLES = 16,
    parameter int unsigned RATE_BASE   = 8,
    parameter int unsigned RATE_STEP   = 2
) (
    input  logic       clk,
    input  logic       por_req,
    input  logic       lvd_req,
    input  logic       osc_fail,
    input  logic       pll_fail,
    input  logic [2:0] opt_rate,
    input  logic       bus_we,
    input  logic [1:0] bus_addr,
    input  logic [7:0] bus_wdata,
    input  logic [1:0] bus_raddr,
    output logic [7:0] bus_rdata,
    output logic       sys_rst,
    output logic [4:0] cause_flags
);
    logic       cop_req;
    logic       req_any;
    logic       hold;
    logic       rst_active;
    logic       wr_ok;
    logic       ctrl_we;
    logic       svc_we;
    logic       clr_we;
    logic [2:0] rate;

    always_comb begin
        req_any = por_req | lvd_req | osc_fail | pll_fail | cop_req;
        hold    = req_any | rst_active;
        wr_ok   = bus_we && !rst_active;
        ctrl_we = wr_ok && (bus_addr == REG_CTRL);
        svc_we  = wr_ok && (bus_addr == REG_SVC);
        clr_we  = wr_ok && (bus_addr == REG_FLAGS);
    end

    rcw_rst_seq #(.HOLD_CYCLES(HOLD_CYCLES)) u_seq (
        .clk        (clk),
        .por_req    (por_req),
        .req_any    (req_any),
        .rst_active (rst_active)
    );

    rcw_cop_timer #(.RATE_BASE(RATE_BASE), .RATE_STEP(RATE_STEP)) u_cop (
        .clk        (clk),
        .por_req    (por_req),
        .hold       (hold),
        .rst_active (rst_active),
        .opt_rate   (opt_rate),
        .ctrl_we    (ctrl_we),
        .svc_we     (svc_we),
        .wdata      (bus_wdata),
        .rate_o     (rate),
        .cop_req    (cop_req)
    );

    rcw_flags u_flags (
        .clk      (clk),
        .por_req  (por_req),
        .lvd_req  (lvd_req),
        .osc_fail (osc_fail),
        .pll_fail (pll_fail),
        .cop_req  (cop_req),
        .clr_we   (clr_we),
        .clr_mask (bus_wdata[FLAG_W-1:0]),
        .flags_o  (cause_flags)
    );

    always_comb begin
        unique case (bus_raddr)
            REG_CTRL:  bus_rdata = {5'b0, rate};
            REG_FLAGS: bus_rdata = {3'b0, cause_flags};
            default:   bus_rdata = 8'h00;
        endcase
    end

    assign sys_rst = rst_active;

    // R4: a clearing write during reset leaves set flags in place
    assert_clear_blocked_R4: assert property (@(posedge clk) disable iff (por_req)
        (sys_rst && bus_we && bus_addr == REG_FLAGS) |=>
            ((~cause_flags & $past(cause_flags)) == '0));
endmodule

// File: tb/reset_cause_wdog_tb.sv
`timescale 1ns/1ps
module reset_cause_wdog_tb;
    localparam int RB = 3;
    localparam int RS = 1;
    localparam int HOLD = 16;

    logic       clk = 1'b0;
    logic       por = 1'b1, lvd = 1'b0, osc = 1'b0, pll = 1'b0;
    logic [2:0] opt = 3'd0;
    logic       we = 1'b0;
    logic [1:0] waddr = 2'd0, raddr = 2'd0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       sys_rst;
    logic [4:0] flags;

    int n_run = 0, n_fail = 0, cyc = 0;

    always #2.5 clk = ~clk;

    reset_cause_wdog #(.HOLD_CYCLES(HOLD), .RATE_BASE(RB), .RATE_STEP(RS)) u_dut (
        .clk(clk), .por_req(por), .lvd_req(lvd), .osc_fail(osc), .pll_fail(pll),
        .opt_rate(opt), .bus_we(we), .bus_addr(waddr), .bus_wdata(wdata),
        .bus_raddr(raddr), .bus_rdata(rdata), .sys_rst(sys_rst), .cause_flags(flags)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    // behavioural reference
    int       m_hold = 0, m_rate = 0, m_cnt = 0;
    bit       m_armed = 0;
    logic [4:0] m_flags = 5'b0;

    always @(posedge clk) begin
        bit busy, en, live, ok, bad, tmo, cop, req;
        int lim;
        cyc++;
        busy = (m_hold != 0);
        en   = (m_rate != 0);
        lim  = 1 << (RB + RS * m_rate);
        live = we && waddr == 2'd1 && !busy && en;
        ok   = live && wdata == 8'hAA && m_armed;
        bad  = live && !ok && wdata != 8'h55;
        tmo  = en && !busy && (m_cnt == lim - 1) && !ok;
        cop  = bad || tmo;
        req  = por || lvd || osc || pll || cop;
        if (por) m_flags = 5'b00011;
        else begin
            if (we && waddr == 2'd2 && !busy) m_flags = m_flags & ~wdata[4:0];
            m_flags = m_flags | {pll, osc, cop, lvd, 1'b0};
        end
        if (req || busy) begin
            m_rate = opt; m_cnt = 0; m_armed = 0;
        end else if (we && waddr == 2'd0) begin
            m_rate = wdata[2:0]; m_cnt = 0; m_armed = 0;
        end else if (en) begin
            if (ok) begin m_cnt = 0; m_armed = 0; end
            else begin
                m_cnt++;
                if (live && wdata == 8'h55) m_armed = 1;
            end
        end
        m_hold = req ? HOLD : (busy ? m_hold - 1 : 0);
    end

    // per-cycle comparison away from the active edge
    always @(negedge clk) begin
        logic [7:0] exp_rd;
        case (raddr)
            2'd0: exp_rd = {5'b0, 3'(m_rate)};
            2'd2: exp_rd = {3'b0, m_flags};
            default: exp_rd = 8'h00;
        endcase
        chk(sys_rst == (m_hold != 0), "R5 model sys_rst", int'(sys_rst), int'(m_hold != 0));
        chk(flags == m_flags, "R2 model flags", int'(flags), int'(m_flags));
        chk(rdata == exp_rd, "R10 model rdata", int'(rdata), int'(exp_rd));
        if (cyc > 150000) begin
            chk(1'b0, "watchdog expired", cyc, 150000);
            finish_run();
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
        #1;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); #1;
        we = 1'b1; waddr = a; wdata = d;
        @(negedge clk); #1;
        we = 1'b0;
    endtask

    task automatic pulse(input bit l, input bit o, input bit p);
        @(negedge clk); #1;
        lvd = l; osc = o; pll = p;
        @(negedge clk); #1;
        lvd = 0; osc = 0; pll = 0;
    endtask

    task automatic wait_release();
        while (sys_rst) begin @(negedge clk); #1; end
    endtask

    initial begin
        int n;
        idle(3);
        @(negedge clk); #1; por = 1'b0;
        wait_release();
        idle(2);
        chk(flags == 5'b00011, "R1 flags after power-on", flags, 5'b00011);
        raddr = 2'd0; #0.1;
        chk(rdata == 8'h00, "R6 rate after power-on with option 0", rdata, 0);

        // R4: zero write no effect, ones clear
        wr(2'd2, 8'h00);
        chk(flags == 5'b00011, "R4 zero write keeps flags", flags, 5'b00011);
        wr(2'd2, 8'h01);
        chk(flags == 5'b00010, "R4 clear bit 0 only", flags, 5'b00010);
        wr(2'd2, 8'h1F);
        chk(flags == 5'b00000, "R4 clear all", flags, 0);

        // R5: reset window length
        pulse(1, 0, 0);
        n = 0;
        while (sys_rst) begin @(negedge clk); #1; n++; end
        chk(n == HOLD - 1 + 1 - 1 + 1, "R5 window length", n, HOLD);
        chk(flags == 5'b00010, "R2 low-voltage flag only", flags, 5'b00010);

        // R4: clear during reset ignored
        pulse(0, 1, 0);
        wr(2'd2, 8'h1F);
        wait_release();
        chk(flags == 5'b01010, "R4 clear ignored during reset", flags, 5'b01010);

        // R4: set beats same-cycle clear
        @(negedge clk); #1;
        we = 1; waddr = 2'd2; wdata = 8'h08; osc = 1;
        @(negedge clk); #1;
        we = 0; osc = 0;
        chk(flags[3] == 1'b1, "R4 set wins over clear", flags[3], 1);
        wait_release();
        wr(2'd2, 8'h1F);

        // R3: simultaneous sources
        pulse(1, 1, 1);
        wait_release();
        chk(flags == 5'b11010, "R3 simultaneous flags", flags, 5'b11010);
        wr(2'd2, 8'h1F);

        // R8: rate 1 timeout = 16 cycles
        wr(2'd0, 8'h01);
        n = 0;
        while (!sys_rst) begin @(negedge clk); #1; n++; end
        chk(n == (1 << (RB + RS)), "R8 timeout rate 1", n, 1 << (RB + RS));
        chk(flags == 5'b00100, "R2 watchdog flag only", flags, 5'b00100);
        wait_release();
        raddr = 2'd0; #0.1;
        chk(rdata == 8'h00, "R6 rate reloaded from option", rdata, 0);

        // R7: disabled watchdog ignores service and never times out
        wr(2'd1, 8'h12);
        idle(1100);
        chk(sys_rst == 1'b0, "R7 no reset while disabled", sys_rst, 0);
        chk(flags == 5'b00100, "R7 flags unchanged while disabled", flags, 5'b00100);
        wr(2'd2, 8'h1F);

        // R6: option rate loaded on a system reset
        opt = 3'd2;
        pulse(0, 0, 1);
        wait_release();
        raddr = 2'd0; #0.1;
        chk(rdata == 8'h02, "R6 option rate 2 loaded", rdata, 2);
        wr(2'd2, 8'h1F);

        // R9: regular service keeps it alive (limit 32)
        for (int k = 0; k < 10; k++) begin
            wr(2'd1, 8'h55);
            idle(4);
            wr(2'd1, 8'h55);
            wr(2'd1, 8'hAA);
            idle(12);
        end
        chk(sys_rst == 1'b0, "R9 serviced watchdog stays quiet", sys_rst, 0);
        chk(flags == 5'b00000, "R9 no watchdog flag when serviced", flags, 0);

        // R9: invalid byte
        wr(2'd1, 8'h12);
        chk(sys_rst == 1'b1, "R9 invalid byte resets at once", sys_rst, 1);
        wait_release();
        chk(flags == 5'b00100, "R9 invalid byte sets watchdog flag", flags, 5'b00100);
        wr(2'd2, 8'h1F);

        // R9: unarmed kick
        wr(2'd1, 8'hAA);
        chk(sys_rst == 1'b1, "R9 unarmed 0xAA resets", sys_rst, 1);
        wait_release();

        // R10: reads of addresses 1 and 3, rate write
        wr(2'd0, 8'hF3);
        raddr = 2'd0; #0.1;
        chk(rdata == 8'h03, "R10 rate field write", rdata, 3);
        raddr = 2'd1; #0.1;
        chk(rdata == 8'h00, "R10 service reads zero", rdata, 0);
        raddr = 2'd3; #0.1;
        chk(rdata == 8'h00, "R10 spare reads zero", rdata, 0);
        wr(2'd0, 8'h00);
        raddr = 2'd2;

        // R1: power-on clears the other flags
        pulse(0, 1, 1);
        wait_release();
        @(negedge clk); #1; por = 1;
        idle(2);
        @(negedge clk); #1; por = 0;
        wait_release();
        chk(flags == 5'b00011, "R1 power-on clears other flags", flags, 5'b00011);

        idle(4);
        finish_run();
    end
endmodule